// File: doc/BRIEF.md
# Bit-Serial Associative Processing Array

A row of identical processing elements, each holding a local data register, a one-bit activity flag and a one-bit carry. A controller broadcasts one instruction at a time. Every element executes it in lockstep, one operand bit per clock, starting at the least significant bit. An instruction names a primary field (an offset and a length into the register, with no alignment rules), a secondary field offset, a scalar operand and a compare mask.

Elements are chosen by what they hold, not by their position. A match instruction compares the scalar against the primary field in every element. Only elements that agree on every compared bit stay active. Write and add instructions then change only active elements. A read instruction returns the primary field of the active element nearest position 0. A summary output tells the controller whether any element is currently active.

At reset each element's register holds its own position number in its low bits. This lets software tell elements apart by content alone.

Top module: `assoc_array`

## Requirements
- R1: After reset `ready` is high, `done` and `read_valid` are low, every activity flag is set so `match_any` is high, and element i holds the value i in its register with all other bits zero.
- R2: An instruction is taken on a clock edge where `instr_valid` and `ready` are both high. `ready` is low from the next cycle on. `done` is high for exactly one cycle, `instr_len` cycles after the accepting edge, and `ready` returns high in that same cycle. Legal lengths are 1 to SCAL_W.
- R3: A match (`instr_op` = 0) sets an element's flag when, for every bit k below the length with `instr_mask[k]` = 1, register bit `off_a+k` equals `instr_scalar[k]`, and clears it otherwise. Mask bits at 0 are don't-care. The flags of all elements are replaced.
- R4: `match_any` is high exactly when at least one activity flag is set.
- R5: A write (`instr_op` = 1) copies the low `instr_len` bits of the scalar into the primary field of every active element.
- R6: An add (`instr_op` = 2) with `instr_vv` = 0 replaces the primary field of every active element with field + scalar, modulo 2^length. The carry starts at zero for every instruction.
- R7: An add with `instr_vv` = 1 replaces the primary field with primary + secondary field (at `instr_off_b`, same length) of the same element, modulo 2^length, for active elements only.
- R8: A read (`instr_op` = 3) pulses `read_valid` together with `done` and puts the primary field of the lowest-numbered active element, zero-extended, on `read_data`. With no element active, `read_valid` stays low.
- R9: The register of an inactive element never changes.
- R10: Activity flags change only when a match completes. Write, add and read leave `match_any` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_op | input | 2 | 0 match, 1 write, 2 add, 3 read |
| instr_vv | input | 1 | Add uses the secondary field instead of the scalar |
| instr_off_a | input | $clog2(REG_W) | Primary field offset |
| instr_off_b | input | $clog2(REG_W) | Secondary field offset |
| instr_len | input | $clog2(SCAL_W+1) | Field length in bits |
| instr_scalar | input | SCAL_W | Broadcast scalar |
| instr_mask | input | SCAL_W | Match compare mask (1 = compare) |
| ready | output | 1 | Idle, can accept an instruction |
| done | output | 1 | One-cycle completion pulse |
| match_any | output | 1 | At least one element active |
| read_valid | output | 1 | Read result valid (with done) |
| read_data | output | SCAL_W | Field read from the first active element |

## Verification
The bench targets the following cases, with the fault each one would expose:
- A mask with zeros must not narrow the selection. A design that compares masked bits would select only one element where four are expected.
- A match that selects nothing must drive `match_any` low, suppress `read_valid`, and let a following write leave every register untouched. A design that gates writes incorrectly would corrupt a later readback.
- Two adds in a row check that the carry is cleared between instructions. A stale carry shows up as an off-by-one sum.
- A vector add runs on only the odd-numbered elements and is then read back from an odd and an even element. This catches wrong-field addressing and writes to inactive elements.
- Single-bit and full-width fields exercise the completion latency at both ends. A wrong count moves the `done` pulse off its expected cycle.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
   typedef enum logic [1:0] {
      OP_MATCH = 2'b00,
      OP_WRITE = 2'b01,
      OP_ADD   = 2'b10,
      OP_READ  = 2'b11
   } assoc_op_e;
endpackage

// File: rtl/assoc_seq.sv
module assoc_seq
   import assoc_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int SCAL_W = 16,
   localparam int OFF_W = $clog2(REG_W),
   localparam int LEN_W = $clog2(SCAL_W + 1),
   localparam int CNT_W = $clog2(SCAL_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [1:0]        instr_op,
   input  logic              instr_vv,
   input  logic [OFF_W-1:0]  instr_off_a,
   input  logic [OFF_W-1:0]  instr_off_b,
   input  logic [LEN_W-1:0]  instr_len,
   input  logic [SCAL_W-1:0] instr_scalar,
   input  logic [SCAL_W-1:0] instr_mask,
   output logic              ready,
   output logic              start,
   output logic              step,
   output logic              last,
   output logic              done,
   output assoc_op_e         op_q,
   output logic              vv_q,
   output logic [CNT_W-1:0]  cnt,
   output logic [OFF_W-1:0]  idx_a,
   output logic [OFF_W-1:0]  idx_b,
   output logic              sbit,
   output logic              mbit
);
   logic              busy_q;
   logic              done_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [OFF_W-1:0]  off_a_q;
   logic [OFF_W-1:0]  off_b_q;
   logic [LEN_W-1:0]  len_q;
   logic [SCAL_W-1:0] scal_q;
   logic [SCAL_W-1:0] mask_q;

   assign ready = ~busy_q;
   assign start = instr_valid & ~busy_q;
   assign step  = busy_q;
   assign last  = busy_q & (cnt_q == CNT_W'(len_q - LEN_W'(1)));
   assign done  = done_q;
   assign cnt   = cnt_q;
   assign idx_a = off_a_q + OFF_W'(cnt_q);
   assign idx_b = off_b_q + OFF_W'(cnt_q);
   assign sbit  = scal_q[cnt_q];
   assign mbit  = mask_q[cnt_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         cnt_q   <= '0;
         op_q    <= OP_MATCH;
         vv_q    <= 1'b0;
         off_a_q <= '0;
         off_b_q <= '0;
         len_q   <= LEN_W'(1);
         scal_q  <= '0;
         mask_q  <= '0;
      end else begin
         done_q <= last;
         if (start) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            op_q    <= assoc_op_e'(instr_op);
            vv_q    <= instr_vv;
            off_a_q <= instr_off_a;
            off_b_q <= instr_off_b;
            len_q   <= instr_len;
            scal_q  <= instr_scalar;
            mask_q  <= instr_mask;
         end else if (busy_q) begin
            if (last) busy_q <= 1'b0;
            else      cnt_q  <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/assoc_pe.sv
module assoc_pe
   import assoc_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int SEED  = 0,
   localparam int OFF_W = $clog2(REG_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step,
   input  logic             last,
   input  assoc_op_e        op,
   input  logic             vv,
   input  logic [OFF_W-1:0] idx_a,
   input  logic [OFF_W-1:0] idx_b,
   input  logic             sbit,
   input  logic             mbit,
   output logic             act_o,
   output logic             bit_a_o,
   output logic [REG_W-1:0] dat_o
);
   logic [REG_W-1:0] dat_q;
   logic             act_q;
   logic             cy_q;
   logic             hit_q;
   logic             a_bit;
   logic             b_bit;
   logic             bit_ok;

   assign a_bit  = dat_q[idx_a];
   assign b_bit  = vv ? dat_q[idx_b] : sbit;
   assign bit_ok = ~mbit | (a_bit == sbit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dat_q <= REG_W'(SEED);
         act_q <= 1'b1;
         cy_q  <= 1'b0;
         hit_q <= 1'b1;
      end else if (start) begin
         cy_q  <= 1'b0;
         hit_q <= 1'b1;
      end else if (step) begin
         case (op)
            OP_MATCH: begin
               hit_q <= hit_q & bit_ok;
               if (last) act_q <= hit_q & bit_ok;
            end
            OP_WRITE: begin
               if (act_q) dat_q[idx_a] <= sbit;
            end
            OP_ADD: begin
               if (act_q) begin
                  dat_q[idx_a] <= a_bit ^ b_bit ^ cy_q;
                  cy_q <= (a_bit & b_bit) | (a_bit & cy_q) | (b_bit & cy_q);
               end
            end
            default: ;
         endcase
      end
   end

   assign act_o   = act_q;
   assign bit_a_o = a_bit;
   assign dat_o   = dat_q;
endmodule

// File: rtl/assoc_pick.sv
module assoc_pick #(
   parameter int N_PE = 8
) (
   input  logic [N_PE-1:0] act,
   input  logic [N_PE-1:0] bits,
   output logic            any,
   output logic            sel_bit
);
   logic [N_PE:0]   seen;
   logic [N_PE-1:0] first;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N_PE; i++) begin : g_chain
      assign first[i]  = act[i] & ~seen[i];
      assign seen[i+1] = seen[i] | act[i];
   end

   assign any     = seen[N_PE];
   assign sel_bit = |(first & bits);
endmodule

// File: rtl/assoc_array.sv
module assoc_array
   import assoc_pkg::*;
#(
   parameter int N_PE   = 8,
   parameter int REG_W  = 32,
   parameter int SCAL_W = 16,
   localparam int OFF_W = $clog2(REG_W),
   localparam int LEN_W = $clog2(SCAL_W + 1),
   localparam int CNT_W = $clog2(SCAL_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [1:0]        instr_op,
   input  logic              instr_vv,
   input  logic [OFF_W-1:0]  instr_off_a,
   input  logic [OFF_W-1:0]  instr_off_b,
   input  logic [LEN_W-1:0]  instr_len,
   input  logic [SCAL_W-1:0] instr_scalar,
   input  logic [SCAL_W-1:0] instr_mask,
   output logic              ready,
   output logic              done,
   output logic              match_any,
   output logic              read_valid,
   output logic [SCAL_W-1:0] read_data
);
   if (N_PE < 1) begin : g_bad_n
      $error("assoc_array: N_PE must be at least 1");
   end
   if (SCAL_W < 2 || SCAL_W > REG_W) begin : g_bad_scal
      $error("assoc_array: SCAL_W must lie in 2..REG_W");
   end
   if ((REG_W & (REG_W - 1)) != 0) begin : g_bad_reg
      $error("assoc_array: REG_W must be a power of two");
   end

   logic             start, step, last, vv_q, sbit, mbit;
   assoc_op_e        op_q;
   logic [CNT_W-1:0] cnt;
   logic [OFF_W-1:0] idx_a, idx_b;

   logic [N_PE-1:0]             act_vec;
   logic [N_PE-1:0]             bit_vec;
   logic [N_PE-1:0][REG_W-1:0]  dat_vec;
   logic                        any_act;
   logic                        sel_bit;
   logic [SCAL_W-1:0]           rd_q;
   logic                        rd_vld_q;

   assoc_seq #(.REG_W(REG_W), .SCAL_W(SCAL_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .instr_valid(instr_valid), .instr_op(instr_op), .instr_vv(instr_vv),
      .instr_off_a(instr_off_a), .instr_off_b(instr_off_b), .instr_len(instr_len),
      .instr_scalar(instr_scalar), .instr_mask(instr_mask),
      .ready(ready), .start(start), .step(step), .last(last), .done(done),
      .op_q(op_q), .vv_q(vv_q), .cnt(cnt), .idx_a(idx_a), .idx_b(idx_b),
      .sbit(sbit), .mbit(mbit)
   );

   for (genvar i = 0; i < N_PE; i++) begin : g_pe
      assoc_pe #(.REG_W(REG_W), .SEED(i)) u_pe (
         .clk(clk), .rst_n(rst_n), .start(start), .step(step), .last(last),
         .op(op_q), .vv(vv_q), .idx_a(idx_a), .idx_b(idx_b),
         .sbit(sbit), .mbit(mbit),
         .act_o(act_vec[i]), .bit_a_o(bit_vec[i]), .dat_o(dat_vec[i])
      );
   end

   assoc_pick #(.N_PE(N_PE)) u_pick (
      .act(act_vec), .bits(bit_vec), .any(any_act), .sel_bit(sel_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q     <= '0;
         rd_vld_q <= 1'b0;
      end else begin
         rd_vld_q <= last & (op_q == OP_READ) & any_act;
         if (start && assoc_op_e'(instr_op) == OP_READ) rd_q <= '0;
         else if (step && op_q == OP_READ) rd_q[cnt] <= sel_bit;
      end
   end

   assign match_any  = any_act;
   assign read_valid = rd_vld_q;
   assign read_data  = rd_q;
endmodule

// File: rtl/assoc_array_chk.sv
module assoc_array_chk #(
   parameter int N_PE   = 8,
   parameter int REG_W  = 32,
   parameter int SCAL_W = 16,
   localparam int LEN_W = $clog2(SCAL_W + 1)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       instr_valid,
   input logic                       ready,
   input logic [LEN_W-1:0]           instr_len,
   input logic                       done,
   input logic                       read_valid,
   input logic [N_PE-1:0]            act_vec,
   input logic [N_PE-1:0][REG_W-1:0] dat_vec
);
   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && ready) |=> (!ready && !done));
   // R2
   legal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && ready) |-> (instr_len != 0 && instr_len <= LEN_W'(SCAL_W)));
   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   read_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      read_valid |-> done);
   // R10
   flags_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_vec) |-> done);
   for (genvar i = 0; i < N_PE; i++) begin : g_hold
      // R9
      inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !act_vec[i] |=> $stable(dat_vec[i]));
   end
endmodule

bind assoc_array assoc_array_chk #(.N_PE(N_PE), .REG_W(REG_W), .SCAL_W(SCAL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .ready(ready),
   .instr_len(instr_len), .done(done), .read_valid(read_valid),
   .act_vec(act_vec), .dat_vec(dat_vec)
);

// File: tb/assoc_array_bench.sv
module assoc_array_bench;
   localparam int NP = 8;
   localparam int RW = 32;
   localparam int SW = 16;
   localparam int OW = $clog2(RW);
   localparam int LW = $clog2(SW + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          instr_valid = 1'b0;
   logic [1:0]    instr_op = '0;
   logic          instr_vv = 1'b0;
   logic [OW-1:0] instr_off_a = '0;
   logic [OW-1:0] instr_off_b = '0;
   logic [LW-1:0] instr_len = LW'(1);
   logic [SW-1:0] instr_scalar = '0;
   logic [SW-1:0] instr_mask = '0;
   logic          ready, done, match_any, read_valid;
   logic [SW-1:0] read_data;

   always #10 clk = ~clk;

   assoc_array #(.N_PE(NP), .REG_W(RW), .SCAL_W(SW)) u_assoc_array (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
      .instr_vv(instr_vv), .instr_off_a(instr_off_a), .instr_off_b(instr_off_b),
      .instr_len(instr_len), .instr_scalar(instr_scalar), .instr_mask(instr_mask),
      .ready(ready), .done(done), .match_any(match_any),
      .read_valid(read_valid), .read_data(read_data)
   );

   typedef struct {
      int            cyc;
      logic          any;
      logic          rv;
      logic [SW-1:0] rd;
      string         rq;
   } exp_t;

   exp_t          sb[$];
   logic [RW-1:0] mdl [NP];
   logic          mact [NP];
   int            cyc = 0;
   int            total = 0;
   int            bad = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] fld(input int i, input int o, input int l);
      logic [SW-1:0] r = '0;
      for (int k = 0; k < l; k++) r[k] = mdl[i][o+k];
      return r;
   endfunction

   task automatic issue(input logic [1:0] op, input logic vv, input int oa, input int ob,
                        input int ln, input logic [SW-1:0] sc, input logic [SW-1:0] mk,
                        input string rq);
      exp_t e;
      @(negedge clk);
      while (!ready) @(negedge clk);
      instr_valid  = 1'b1;
      instr_op     = op;
      instr_vv     = vv;
      instr_off_a  = OW'(oa);
      instr_off_b  = OW'(ob);
      instr_len    = LW'(ln);
      instr_scalar = sc;
      instr_mask   = mk;
      e.cyc = cyc + 1 + ln;
      e.rv  = 1'b0;
      e.rd  = '0;
      e.rq  = rq;
      for (int i = 0; i < NP; i++) begin
         case (op)
            2'd0: begin
               mact[i] = 1'b1;
               for (int k = 0; k < ln; k++)
                  if (mk[k] && mdl[i][oa+k] != sc[k]) mact[i] = 1'b0;
            end
            2'd1: if (mact[i]) for (int k = 0; k < ln; k++) mdl[i][oa+k] = sc[k];
            2'd2: if (mact[i]) begin
               logic [SW:0] s;
               s = {1'b0, fld(i, oa, ln)} + {1'b0, (vv ? fld(i, ob, ln) : sc)};
               for (int k = 0; k < ln; k++) mdl[i][oa+k] = s[k];
            end
            default: if (mact[i] && !e.rv) begin
               e.rv = 1'b1;
               e.rd = fld(i, oa, ln);
            end
         endcase
      end
      e.any = 1'b0;
      for (int i = 0; i < NP; i++) e.any = e.any | mact[i];
      sb.push_back(e);
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R2 unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(cyc == e.cyc, {"R2 done cycle ", e.rq}, 32'(cyc), 32'(e.cyc));
            chk(match_any == e.any, {"R4 R10 match_any ", e.rq}, 32'(match_any), 32'(e.any));
            chk(read_valid == e.rv, {"R8 read_valid ", e.rq}, 32'(read_valid), 32'(e.rv));
            if (e.rv) chk(read_data == e.rd, {"data ", e.rq}, 32'(read_data), 32'(e.rd));
         end
      end
   end

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "R2 watchdog", 32'd0, 32'd1);
      summary();
   end

   initial begin
      for (int i = 0; i < NP; i++) begin
         mdl[i]  = RW'(i);
         mact[i] = 1'b1;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ready == 1'b1, "R1 ready", 32'(ready), 32'd1);
      chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
      chk(match_any == 1'b1, "R1 match_any", 32'(match_any), 32'd1);
      chk(read_valid == 1'b0, "R1 read_valid", 32'(read_valid), 32'd0);

      issue(2'd3, 0, 0, 0, 3, '0, '0, "R1 seed of element 0");
      issue(2'd0, 0, 0, 0, 3, 16'd5, 16'h7, "R3 select index 5");
      issue(2'd3, 0, 0, 0, 3, '0, '0, "R3 R8 read index 5");
      issue(2'd1, 0, 8, 0, 8, 16'hAB, '0, "R5 write one element");
      issue(2'd0, 0, 0, 0, 3, 16'd0, 16'h0, "R3 all masked selects all");
      issue(2'd3, 0, 8, 0, 8, '0, '0, "R9 element 0 untouched");
      issue(2'd0, 0, 0, 0, 3, 16'd5, 16'h7, "R3 reselect 5");
      issue(2'd3, 0, 8, 0, 8, '0, '0, "R5 written value");
      issue(2'd0, 0, 3, 0, 5, 16'd1, 16'h1F, "R4 match none");
      issue(2'd3, 0, 8, 0, 8, '0, '0, "R8 read with none active");
      issue(2'd1, 0, 8, 0, 8, 16'hFF, '0, "R9 write with none active");
      issue(2'd0, 0, 0, 0, 3, 16'd5, 16'h7, "R3 reselect 5 again");
      issue(2'd3, 0, 8, 0, 8, '0, '0, "R9 value kept");
      issue(2'd0, 0, 0, 0, 1, 16'd0, 16'h0, "R3 select all");
      issue(2'd1, 0, 16, 0, 8, 16'hF0, '0, "R5 broadcast write");
      issue(2'd2, 0, 16, 0, 8, 16'h25, '0, "R6 scalar add wraps");
      issue(2'd3, 0, 16, 0, 8, '0, '0, "R6 sum read");
      issue(2'd2, 0, 16, 0, 8, 16'h01, '0, "R6 carry cleared");
      issue(2'd3, 0, 16, 0, 8, '0, '0, "R6 second sum");
      issue(2'd0, 0, 0, 0, 3, 16'd1, 16'h1, "R3 odd elements via mask");
      issue(2'd3, 0, 0, 0, 3, '0, '0, "R3 R8 lowest odd");
      issue(2'd2, 1, 16, 0, 8, '0, '0, "R7 vector add odd only");
      issue(2'd0, 0, 0, 0, 3, 16'd3, 16'h7, "R3 select 3");
      issue(2'd3, 0, 16, 0, 8, '0, '0, "R7 vector sum");
      issue(2'd0, 0, 0, 0, 3, 16'd2, 16'h7, "R3 select 2");
      issue(2'd3, 0, 16, 0, 8, '0, '0, "R9 even element kept");
      issue(2'd0, 0, 0, 0, 1, 16'd0, 16'h0, "R3 select all again");
      issue(2'd1, 0, 16, 0, 16, 16'hBEEF, '0, "R5 full-width write");
      issue(2'd1, 0, 28, 0, 1, 16'h0, '0, "R2 R5 one-bit write");
      issue(2'd3, 0, 16, 0, 16, '0, '0, "R8 full-width read");
      repeat (SW + 8) @(negedge clk);
      chk(sb.size() == 0, "R2 all instructions completed", 32'(sb.size()), 32'd0);
      summary();
   end
endmodule